// File: doc/BRIEF.md
# Two-Processor Interrupt Mailbox Controller

This block connects a main CPU and a coprocessor through a small set of byte-wide registers. Either side can raise interrupt requests toward the other side and leave a 4-bit message for it. Each side has an enable register, a clear register and a readable flag register. The block keeps one pending flag per interrupt source.

Toward the main CPU it drives a registered, level-sensitive interrupt line. This line is set by an enabled request and released only when every host-side pending flag has been cleared. Toward the coprocessor it drives IRQ and NMI request lines. These are formed from pending flags gated by their enables. Timer, DMA and character-conversion-DMA completion events come in as single-cycle pulses.

The register write port and read port are shared and synchronous to one clock. Writes take effect at the rising edge on which `wr_en` is sampled. Reads are combinational from `rd_addr`.

Top module: `irq_mailbox_ctrl`

## Requirements
- R1: After reset all pending flags, enables, vector-select bits and message nibbles are zero, the three interrupt outputs are low, and both flag registers read 0x00.
- R2: A write to offset 0 (coprocessor control) sets the coprocessor IRQ flag when bit 7 is 1 and the coprocessor NMI flag when bit 4 is 1. It stores bits 3:0 as the coprocessor message. A 0 in bit 7 or bit 4 leaves the matching flag unchanged.
- R3: A write to offset 3 (host control) sets the host IRQ flag when bit 7 is 1. It stores bit 6 and bit 4 as vector-select bits and bits 3:0 as the host message. If the host IRQ enable is already 1 when bit 7 is written, `host_irq_o` is high from the next cycle on.
- R4: Offset 1 (host enable) holds the host IRQ enable in bit 7 and the character-DMA enable in bit 5. If a write turns either enable from 0 to 1 while its flag is pending, `host_irq_o` is high from the next cycle on.
- R5: A 1 in bit 7 or bit 5 of a write to offset 2 (host clear) clears the host IRQ or character-DMA flag. `host_irq_o` goes low only after a clear write that leaves both host flags clear. Clearing an enable does not drop the line.
- R6: A `cdma_evt` pulse sets the character-DMA flag. If the character-DMA enable is 1, it also raises `host_irq_o` from the next cycle on.
- R7: Offset 4 (coprocessor enable) holds the enables for IRQ (bit 7), timer (bit 6), DMA (bit 5) and NMI (bit 4). `cop_irq_o` is the OR, over the IRQ, timer and DMA sources, of each flag ANDed with its enable. `cop_nmi_o` is the NMI flag ANDed with its enable. Enabling a source whose flag is already pending raises the output in the next cycle.
- R8: A 1 in a bit of a write to offset 5 (coprocessor clear) clears the flag that uses the same bit position in the enable register.
- R9: A `tmr_evt` or `dma_evt` pulse sets the timer or DMA flag. When an event pulse and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: Reading offset 0 returns {host IRQ flag, bit-6 vector select, character-DMA flag, bit-4 vector select, host message} from bit 7 down to bit 0. Reading offset 1 returns {IRQ flag, timer flag, DMA flag, NMI flag, coprocessor message}. Any other read offset returns zero, and a write to an unused offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register offset |
| rd_data | output | DATA_W | Combinational read data |
| tmr_evt | input | 1 | Timer event pulse for the coprocessor |
| dma_evt | input | 1 | DMA event pulse for the coprocessor |
| cdma_evt | input | 1 | Character-DMA completion pulse for the main CPU |
| host_irq_o | output | 1 | Level interrupt to the main CPU |
| cop_irq_o | output | 1 | IRQ request to the coprocessor |
| cop_nmi_o | output | 1 | NMI request to the coprocessor |

## Verification
The bench targets the host line's stickiness in four cases:
- It disables the host enable while a request is active. A design that gates the line by the enable would drop it there.
- It clears one host flag while the other is still pending. A design that drops on any clear would release the line early.
- It turns on an enable over a flag that is already pending. A design that only fires on new requests would miss this interrupt.
- It writes bit 7 to host control while the enable is off. A design that ignored the enable would fire the line anyway.

It also drives an event pulse and a clear of the same flag in one cycle, where a clear-wins design would lose the event. It writes zeros to the control registers, which must not disturb pending flags. It reads unused offsets to catch decode aliasing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // write register offsets
   localparam int unsigned OFS_COP_CTL  = 0;
   localparam int unsigned OFS_HOST_EN  = 1;
   localparam int unsigned OFS_HOST_CLR = 2;
   localparam int unsigned OFS_HOST_CTL = 3;
   localparam int unsigned OFS_COP_EN   = 4;
   localparam int unsigned OFS_COP_CLR  = 5;
   localparam int unsigned NUM_WREG     = 6;
   // read register offsets
   localparam int unsigned OFS_RD_HOST  = 0;
   localparam int unsigned OFS_RD_COP   = 1;
   // coprocessor source index; its register bit is 7 - index
   localparam int unsigned CS_IRQ = 0;
   localparam int unsigned CS_TMR = 1;
   localparam int unsigned CS_DMA = 2;
   localparam int unsigned CS_NMI = 3;
   localparam int unsigned NUM_CS = 4;
   // host source index
   localparam int unsigned HS_CPU  = 0;
   localparam int unsigned HS_CDMA = 1;
   localparam int unsigned NUM_HS  = 2;
   // shared bit positions
   localparam int unsigned B_REQ  = 7;
   localparam int unsigned B_VEC6 = 6;
   localparam int unsigned B_AUX  = 5;
   localparam int unsigned B_NMI4 = 4;
   localparam int unsigned MSG_W  = 4;
endpackage

// File: rtl/mbx_wr_decode.sv
module mbx_wr_decode #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NUM    = 6
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [NUM-1:0]    strobe_o
);
   if ((1 << ADDR_W) < NUM) begin : g_bad_addr_w
      $error("mbx_wr_decode: ADDR_W too small for NUM registers");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_stb
      assign strobe_o[g] = wr_en && (wr_addr == ADDR_W'(g));
   end
endmodule

// File: rtl/mbx_pend_bit.sv
module mbx_pend_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic d_o
);
   if (SET_WINS) begin : g_set_pri
      assign d_o = set_i | (q_o & ~clr_i);
   end else begin : g_clr_pri
      assign d_o = ~clr_i & (set_i | q_o);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d_o;
   end
endmodule

// File: rtl/mbx_host_line.sv
module mbx_host_line #(
   parameter int unsigned NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] en_q_i,
   input  logic            en_wr_i,
   input  logic [NSRC-1:0] en_new_i,
   input  logic            clr_wr_i,
   input  logic [NSRC-1:0] flag_q_i,
   input  logic [NSRC-1:0] flag_d_i,
   output logic            line_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("mbx_host_line: NSRC must be at least 1");
   end

   logic fire, drop;

   always_comb begin
      // a fresh enabled request, or an enable turning on over a pending flag
      fire = |(set_i & en_q_i) | (en_wr_i & |(en_new_i & ~en_q_i & flag_q_i));
      // released only by a clear write that leaves nothing pending
      drop = clr_wr_i & ~|flag_d_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    line_o <= 1'b0;
      else if (fire) line_o <= 1'b1;
      else if (drop) line_o <= 1'b0;
   end
endmodule

// File: rtl/irq_mailbox_ctrl.sv
module irq_mailbox_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tmr_evt,
   input  logic              dma_evt,
   input  logic              cdma_evt,
   output logic              host_irq_o,
   output logic              cop_irq_o,
   output logic              cop_nmi_o
);
   if (DATA_W < 8) begin : g_bad_data_w
      $error("irq_mailbox_ctrl: DATA_W must be at least 8");
   end

   localparam int unsigned NREQ = NUM_CS - 1;  // sources feeding cop_irq_o

   logic [NUM_WREG-1:0] wstb;
   logic [7:0]          wd;
   assign wd = wr_data[7:0];

   mbx_wr_decode #(.ADDR_W(ADDR_W), .NUM(NUM_WREG)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .strobe_o (wstb)
   );

   // ---------------- coprocessor side ----------------
   logic [NUM_CS-1:0] cop_set, cop_clr, cop_flag_q, cop_nxt_unused, cop_en_q;
   logic [MSG_W-1:0]  cop_msg_q;

   always_comb begin
      cop_set         = '0;
      cop_set[CS_IRQ] = wstb[OFS_COP_CTL] & wd[B_REQ];
      cop_set[CS_TMR] = tmr_evt;
      cop_set[CS_DMA] = dma_evt;
      cop_set[CS_NMI] = wstb[OFS_COP_CTL] & wd[B_NMI4];
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cop
      assign cop_clr[i] = wstb[OFS_COP_CLR] & wd[B_REQ-i];
      mbx_pend_bit #(.SET_WINS(SET_WINS)) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (cop_set[i]),
         .clr_i (cop_clr[i]),
         .q_o   (cop_flag_q[i]),
         .d_o   (cop_nxt_unused[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cop_en_q  <= '0;
         cop_msg_q <= '0;
      end else begin
         if (wstb[OFS_COP_EN])  cop_en_q  <= {wd[B_NMI4], wd[B_AUX], wd[B_VEC6], wd[B_REQ]};
         if (wstb[OFS_COP_CTL]) cop_msg_q <= wd[MSG_W-1:0];
      end
   end

   assign cop_irq_o = |(cop_flag_q[NREQ-1:0] & cop_en_q[NREQ-1:0]);
   assign cop_nmi_o = cop_flag_q[CS_NMI] & cop_en_q[CS_NMI];

   // ---------------- main CPU side ----------------
   logic [NUM_HS-1:0] host_set, host_clr, host_flag_q, host_flag_d, host_en_q, host_en_new;
   logic [1:0]        host_vec_q;  // [1] from bit 6, [0] from bit 4
   logic [MSG_W-1:0]  host_msg_q;

   always_comb begin
      host_set           = '0;
      host_set[HS_CPU]   = wstb[OFS_HOST_CTL] & wd[B_REQ];
      host_set[HS_CDMA]  = cdma_evt;
      host_clr           = '0;
      host_clr[HS_CPU]   = wstb[OFS_HOST_CLR] & wd[B_REQ];
      host_clr[HS_CDMA]  = wstb[OFS_HOST_CLR] & wd[B_AUX];
      host_en_new          = '0;
      host_en_new[HS_CPU]  = wd[B_REQ];
      host_en_new[HS_CDMA] = wd[B_AUX];
   end

   for (genvar h = 0; h < NUM_HS; h++) begin : g_host
      mbx_pend_bit #(.SET_WINS(SET_WINS)) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (host_set[h]),
         .clr_i (host_clr[h]),
         .q_o   (host_flag_q[h]),
         .d_o   (host_flag_d[h])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_en_q  <= '0;
         host_vec_q <= '0;
         host_msg_q <= '0;
      end else begin
         if (wstb[OFS_HOST_EN]) host_en_q <= host_en_new;
         if (wstb[OFS_HOST_CTL]) begin
            host_vec_q <= {wd[B_VEC6], wd[B_NMI4]};
            host_msg_q <= wd[MSG_W-1:0];
         end
      end
   end

   mbx_host_line #(.NSRC(NUM_HS)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (host_set),
      .en_q_i   (host_en_q),
      .en_wr_i  (wstb[OFS_HOST_EN]),
      .en_new_i (host_en_new),
      .clr_wr_i (wstb[OFS_HOST_CLR]),
      .flag_q_i (host_flag_q),
      .flag_d_i (host_flag_d),
      .line_o   (host_irq_o)
   );

   // ---------------- read path ----------------
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFS_RD_HOST)) begin
         rd_data[7:0] = {host_flag_q[HS_CPU], host_vec_q[1], host_flag_q[HS_CDMA],
                         host_vec_q[0], host_msg_q};
      end else if (rd_addr == ADDR_W'(OFS_RD_COP)) begin
         rd_data[7:0] = {cop_flag_q[CS_IRQ], cop_flag_q[CS_TMR], cop_flag_q[CS_DMA],
                         cop_flag_q[CS_NMI], cop_msg_q};
      end
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:4]        wr_hi,
   input logic              tmr_evt,
   input logic              dma_evt,
   input logic              host_irq_o,
   input logic              cop_irq_o,
   input logic              cop_nmi_o,
   input logic [1:0]        host_flag,
   input logic [1:0]        host_en,
   input logic [3:0]        cop_flag
);
   logic w_hctl, w_hen, w_cclr;
   assign w_hctl = wr_en && (wr_addr == ADDR_W'(OFS_HOST_CTL));
   assign w_hen  = wr_en && (wr_addr == ADDR_W'(OFS_HOST_EN));
   assign w_cclr = wr_en && (wr_addr == ADDR_W'(OFS_COP_CLR));

   AST_HOST_FIRE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (w_hctl && wr_hi[7] && host_en[0]) |=> host_irq_o);  // R3

   AST_HOST_FIRE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (w_hen && wr_hi[7] && !host_en[0] && host_flag[0]) |=> host_irq_o);  // R4

   AST_HOST_DROP_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_irq_o) |-> (host_flag == 2'b00));  // R5

   AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cclr && wr_hi[4]) |=> !cop_nmi_o);  // R8

   AST_COP_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cclr && wr_hi[7:5] == 3'b111 && !tmr_evt && !dma_evt) |=> !cop_irq_o);  // R8

   AST_TMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt |=> cop_flag[1]);  // R9

   AST_DMA_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      dma_evt |=> cop_flag[2]);  // R9
endmodule

bind irq_mailbox_ctrl mbx_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_hi      (wr_data[7:4]),
   .tmr_evt    (tmr_evt),
   .dma_evt    (dma_evt),
   .host_irq_o (host_irq_o),
   .cop_irq_o  (cop_irq_o),
   .cop_nmi_o  (cop_nmi_o),
   .host_flag  (host_flag_q),
   .host_en    (host_en_q),
   .cop_flag   (cop_flag_q)
);

// File: tb/irq_mailbox_ctrl_tb_top.sv
module irq_mailbox_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       tmr_evt = 1'b0, dma_evt = 1'b0, cdma_evt = 1'b0;
   logic       host_irq_o, cop_irq_o, cop_nmi_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   irq_mailbox_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tmr_evt(tmr_evt), .dma_evt(dma_evt),
      .cdma_evt(cdma_evt), .host_irq_o(host_irq_o), .cop_irq_o(cop_irq_o),
      .cop_nmi_o(cop_nmi_o)
   );

   // ---------------- behavioural reference ----------------
   bit       m_hreq, m_hcdma, m_hen_req, m_hen_cdma, m_v6, m_v4, m_line;
   bit [3:0] m_hmsg, m_cmsg;
   bit       m_cf [4];   // irq, timer, dma, nmi
   bit       m_ce [4];

   function automatic bit [7:0] exp_host_rd();
      return {m_hreq, m_v6, m_hcdma, m_v4, m_hmsg};
   endfunction
   function automatic bit [7:0] exp_cop_rd();
      return {m_cf[0], m_cf[1], m_cf[2], m_cf[3], m_cmsg};
   endfunction

   task automatic model(input bit we, input int a, input bit [7:0] d,
                        input bit te, input bit de, input bit ce);
      bit fire = 0, drop = 0;
      if (we && a == 3) begin
         if (d[7]) begin m_hreq = 1; if (m_hen_req) fire = 1; end
         m_v6 = d[6]; m_v4 = d[4]; m_hmsg = d[3:0];
      end
      if (we && a == 2) begin
         if (d[7]) m_hreq = 0;
         if (d[5] && !ce) m_hcdma = 0;
         if (!m_hreq && !m_hcdma && !ce) drop = 1;
      end
      if (ce) begin m_hcdma = 1; if (m_hen_cdma) fire = 1; end
      if (we && a == 1) begin
         if (d[7] && !m_hen_req && m_hreq) fire = 1;
         if (d[5] && !m_hen_cdma && m_hcdma) fire = 1;
         m_hen_req = d[7]; m_hen_cdma = d[5];
      end
      if (fire) m_line = 1; else if (drop) m_line = 0;
      if (we && a == 0) begin
         if (d[7]) m_cf[0] = 1;
         if (d[4]) m_cf[3] = 1;
         m_cmsg = d[3:0];
      end
      if (we && a == 5) for (int k = 0; k < 4; k++) if (d[7-k]) m_cf[k] = 0;
      if (te) m_cf[1] = 1;
      if (de) m_cf[2] = 1;
      if (we && a == 4) for (int k = 0; k < 4; k++) m_ce[k] = d[7-k];
   endtask

   task automatic chk(input bit [7:0] act, input bit [7:0] exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit e_ci, e_cn;
      e_ci = (m_cf[0] & m_ce[0]) | (m_cf[1] & m_ce[1]) | (m_cf[2] & m_ce[2]);
      e_cn = m_cf[3] & m_ce[3];
      rd_addr = 3'd0; #1;
      chk(rd_data, exp_host_rd(), tag, "host flag read");
      rd_addr = 3'd1; #1;
      chk(rd_data, exp_cop_rd(), tag, "cop flag read");
      rd_addr = 3'd6; #1;
      chk(rd_data, 8'h00, "R10", "unused read offset");
      chk({7'd0, host_irq_o}, {7'd0, m_line}, tag, "host_irq_o");
      chk({7'd0, cop_irq_o}, {7'd0, e_ci}, tag, "cop_irq_o");
      chk({7'd0, cop_nmi_o}, {7'd0, e_cn}, tag, "cop_nmi_o");
   endtask

   task automatic step(input bit we, input int a, input bit [7:0] d,
                       input bit te, input bit de, input bit ce, input string tag);
      @(negedge clk);
      wr_en = we; wr_addr = a[2:0]; wr_data = d;
      tmr_evt = te; dma_evt = de; cdma_evt = ce;
      @(posedge clk);
      model(we, a, d, te, de, ce);
      #2;
      wr_en = 0; tmr_evt = 0; dma_evt = 0; cdma_evt = 0;
      #2;
      compare(tag);
   endtask

   task automatic wr(input int a, input bit [7:0] d, input string tag);
      step(1, a, d, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2 compare("R1");

      // host side
      wr(1, 8'h80, "R4");             // enable with nothing pending: no fire
      wr(3, 8'hD5, "R3");             // request, vectors, message; enabled -> line
      wr(1, 8'h00, "R5");             // disabling does not drop the line
      step(0, 0, 8'h00, 0, 0, 1, "R6"); // char-DMA pulse, enable off
      wr(2, 8'h80, "R5");             // one flag still pending: line stays
      wr(2, 8'h20, "R5");             // both clear: line drops
      wr(1, 8'h20, "R4");
      step(0, 0, 8'h00, 0, 0, 1, "R6"); // enabled char-DMA pulse raises line
      step(1, 2, 8'h20, 0, 0, 1, "R9"); // pulse and clear together: set wins
      wr(2, 8'hA0, "R5");
      wr(1, 8'h00, "R4");
      wr(3, 8'h8A, "R3");             // request while disabled: flag only
      wr(1, 8'h80, "R4");             // enabling over a pending flag fires
      wr(3, 8'h00, "R3");             // zero write keeps flag, updates message
      wr(2, 8'h80, "R5");
      wr(7, 8'hFF, "R10");            // unused offset changes nothing

      // coprocessor side
      wr(0, 8'h9A, "R2");
      wr(4, 8'h10, "R7");             // NMI enabled over pending flag
      wr(4, 8'hF0, "R7");             // IRQ enabled
      wr(0, 8'h03, "R2");             // zero bits do not clear
      wr(5, 8'h80, "R8");
      step(0, 0, 8'h00, 1, 0, 0, "R9"); // timer pulse
      step(1, 5, 8'h40, 1, 0, 0, "R9"); // timer pulse and clear: set wins
      wr(5, 8'h40, "R8");
      step(0, 0, 8'h00, 0, 1, 0, "R9"); // DMA pulse
      wr(4, 8'h50, "R7");             // DMA disabled: IRQ out low, flag stays
      step(1, 5, 8'h20, 0, 1, 0, "R9");
      wr(5, 8'h30, "R8");             // clears DMA and NMI
      wr(4, 8'h00, "R7");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule